// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Transmitter

This block turns parallel two-channel PCM samples into a three-wire serial audio stream and acts as the clock master. It creates the bit clock and the word clock itself from the system clock, paced by a master clock enable. It sends each sample most significant bit first. A two-bit mode input picks one of three framings at run time: standard I2S, left-justified or right-justified. The word clock and the serial data both change only on falling bit-clock edges, so a receiver can sample on rising edges.

A frame is 64 bit clocks long. The left channel fills the first 32-bit slot, while the word clock is low. The right channel fills the second slot, while the word clock is high. A sample narrower than the slot is padded with zeros. A sample pair offered with the valid strobe is held in a pending buffer. It is moved into the active pair when the next left slot starts. If no new pair has arrived by then, the active pair is sent again.

Top module: `i2s_serializer`

## Requirements
- R1: While reset is asserted, the bit clock, word clock and serial data outputs are all 0.
- R2: The bit clock toggles after every HALF_DIV clock cycles in which the master clock enable is high. With the enable held high, the high and low phases each last HALF_DIV cycles. While the enable is low, the bit clock does not change.
- R3: One frame is 64 bit clocks long. The word clock is low for 32 bit clocks, marking the left slot, and high for 32 bit clocks, marking the right slot.
- R4: The word clock and the serial data change only in the cycle in which the bit clock falls.
- R5: With mode 1 (left-justified), the sample MSB is the first bit of its slot. It is driven in the same falling edge that moves the word clock, and the bits that follow run down to the LSB.
- R6: With mode 0 (standard I2S), the word clock changes one bit period before the slot's MSB. The MSB goes out on the bit after the word-clock edge.
- R7: With mode 2 (right-justified), the LSB is the last bit before the next word-clock edge. The sample bits are sent MSB first and end at the slot boundary.
- R8: Slot bit positions that the SAMPLE_W-bit sample does not fill are sent as 0. In modes 0 and 1 these are the trailing positions; in mode 2 they are the leading positions.
- R9: A pair given with sampleValid is sent from the next left slot on. Without a new pair, every following frame repeats the last pair sent.
- R10: Mode 3 frames the stream exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mclkEn | input | 1 | Master clock enable that paces the bit clock |
| modeIn | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 as 0 |
| sampleValid | input | 1 | One-cycle strobe that offers a new sample pair |
| leftIn | input | SAMPLE_W | Left channel sample |
| rightIn | input | SAMPLE_W | Right channel sample |
| bclk | output | 1 | Serial bit clock |
| wclk | output | 1 | Word (channel select) clock, low for the left slot |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The bench uses the default parameters: SAMPLE_W of 24 and HALF_DIV of 2. A 24-bit sample leaves eight padding positions in every 32-bit slot. These sit at the tail in I2S and left-justified modes and at the head in right-justified mode, so every framing checks both the data alignment and the zero padding. A half period of two cycles gives a phase length that can be measured, so the duty check is meaningful, and it keeps each frame short enough to capture several consecutive frames. Those frames show whether a pair is repeated and whether a new pair appears at the left-slot boundary.

// File: rtl/i2s_ser_pkg.sv
package i2s_ser_pkg;
  localparam int SLOT_BITS  = 32;
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ   = 2'd2,
    FMT_I2S3 = 2'd3
  } fmt_e;

  typedef struct packed {
    logic             fall;
    logic             frameStart;
    logic [POS_W-1:0] pos;
  } ctrlStrobe_t;
endpackage

// File: rtl/i2s_ser_ctrl.sv
module i2s_ser_ctrl
  import i2s_ser_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mclkEn,
  output logic        bclkOut,
  output ctrlStrobe_t strb
);
  localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_DIV - 1);

  logic [HC_W-1:0]  halfCnt;
  logic             bclkR;
  logic [POS_W-1:0] bitCnt;
  logic             halfDone;
  logic             fallNow;
  logic [POS_W-1:0] nextPos;

  always_comb begin
    halfDone = mclkEn && (halfCnt == HC_LAST);
    fallNow  = halfDone && bclkR;
    nextPos  = bitCnt + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      bclkR   <= 1'b0;
      bitCnt  <= '1;
    end else if (mclkEn) begin
      if (halfDone) begin
        halfCnt <= '0;
        bclkR   <= ~bclkR;
        if (bclkR) bitCnt <= nextPos;
      end else begin
        halfCnt <= halfCnt + HC_W'(1);
      end
    end
  end

  always_comb begin
    strb.fall       = fallNow;
    strb.frameStart = fallNow && (nextPos == '0);
    strb.pos        = nextPos;
  end

  assign bclkOut = bclkR;
endmodule

// File: rtl/i2s_ser_datapath.sv
module i2s_ser_datapath
  import i2s_ser_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [1:0]          modeIn,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                wclkOut,
  output logic                sdataOut
);
  localparam int PAD = SLOT_BITS - SAMPLE_W;

  logic [SAMPLE_W-1:0] pendL, pendR, actL, actR;
  logic                pendV;
  fmt_e                curMode;

  logic                loadNew;
  logic [SAMPLE_W-1:0] frmL, frmR, word;
  fmt_e                frmMode;
  logic [SLOT_BITS-1:0] slotWord;
  logic [4:0]          idx;
  logic [POS_W-1:0]    posAhead;
  logic                nextWclk, nextBit;

  always_comb begin
    loadNew  = strb.frameStart && pendV;
    frmL     = loadNew ? pendL : actL;
    frmR     = loadNew ? pendR : actR;
    frmMode  = strb.frameStart ? fmt_e'(modeIn) : curMode;
    idx      = strb.pos[4:0];
    word     = strb.pos[POS_W-1] ? frmR : frmL;
    posAhead = strb.pos + POS_W'(1);
    if (frmMode == FMT_RJ) slotWord = SLOT_BITS'(word);
    else                   slotWord = SLOT_BITS'(word) << PAD;
    nextBit  = slotWord[5'd31 - idx];
    if (frmMode == FMT_I2S || frmMode == FMT_I2S3) nextWclk = posAhead[POS_W-1];
    else                                          nextWclk = strb.pos[POS_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendL <= '0;
      pendR <= '0;
      pendV <= 1'b0;
    end else if (sampleValid) begin
      pendL <= leftIn;
      pendR <= rightIn;
      pendV <= 1'b1;
    end else if (strb.frameStart) begin
      pendV <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actL    <= '0;
      actR    <= '0;
      curMode <= FMT_I2S;
    end else if (strb.frameStart) begin
      actL    <= frmL;
      actR    <= frmR;
      curMode <= frmMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wclkOut  <= 1'b0;
      sdataOut <= 1'b0;
    end else if (strb.fall) begin
      wclkOut  <= nextWclk;
      sdataOut <= nextBit;
    end
  end
endmodule

// File: rtl/i2s_serializer.sv
module i2s_serializer
  import i2s_ser_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                mclkEn,
  input  logic [1:0]          modeIn,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                bclk,
  output logic                wclk,
  output logic                sdata
);
  ctrlStrobe_t strb;

  i2s_ser_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .mclkEn  (mclkEn),
    .bclkOut (bclk),
    .strb    (strb)
  );

  i2s_ser_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .modeIn      (modeIn),
    .sampleValid (sampleValid),
    .leftIn      (leftIn),
    .rightIn     (rightIn),
    .wclkOut     (wclk),
    .sdataOut    (sdata)
  );
endmodule

// File: rtl/i2s_serializer_checker.sv
module i2s_serializer_checker (
  input logic       clk,
  input logic       rstN,
  input logic       mclkEn,
  input logic [1:0] modeIn,
  input logic       bclk,
  input logic       wclk,
  input logic       sdata
);
  logic       prevB, prevW, prevD, prevEn;
  logic [1:0] prevMode;
  logic [5:0] fallCnt;
  logic [2:0] cleanCnt;
  logic       fallNow, wEdge;

  assign fallNow = prevB && !bclk;
  assign wEdge   = (wclk != prevW);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevB    <= 1'b0;
      prevW    <= 1'b0;
      prevD    <= 1'b0;
      prevEn   <= 1'b0;
      prevMode <= 2'd0;
      fallCnt  <= '0;
      cleanCnt <= '0;
    end else begin
      prevB    <= bclk;
      prevW    <= wclk;
      prevD    <= sdata;
      prevEn   <= mclkEn;
      prevMode <= modeIn;
      if (fallNow) fallCnt <= wEdge ? 6'd0 : fallCnt + 6'd1;
      if (modeIn != prevMode) cleanCnt <= '0;
      else if (fallNow && wEdge && cleanCnt < 3'd4) cleanCnt <= cleanCnt + 3'd1;
    end
  end

  // R2: bit clock moves only after an enabled cycle
  a_r2_bclk_gated: assert property (@(posedge clk) disable iff (!rstN)
    (bclk != prevB) |-> prevEn);

  // R4: word clock changes only with a falling bit clock
  a_r4_wclk_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (wclk != prevW) |-> (prevB && !bclk));

  // R4: serial data changes only with a falling bit clock
  a_r4_sdata_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (sdata != prevD) |-> (prevB && !bclk));

  // R3: each word-clock phase spans 32 bit clocks once the mode has settled
  a_r3_slot_len: assert property (@(posedge clk) disable iff (!rstN)
    (fallNow && wEdge && cleanCnt == 3'd4) |-> (fallCnt == 6'd31));
endmodule

bind i2s_serializer i2s_serializer_checker u_chk (.*);

// File: tb/test_i2s_serializer.sv
`timescale 1ns/1ps
module test_i2s_serializer;
  localparam int SW = 24;
  localparam int HD = 2;
  localparam int RECN = 200;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          mclkEn = 1'b0;
  logic [1:0]    modeIn = 2'd1;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] leftIn = '0;
  logic [SW-1:0] rightIn = '0;
  logic          bclk, wclk, sdata;

  int nChecks = 0;
  int nFails  = 0;
  int edgeErr = 0;

  logic recW [RECN];
  logic recD [RECN];
  int   recN = 0;
  logic recOn = 1'b0;
  logic pb = 1'b0, pw = 1'b0, pd = 1'b0;
  logic monOn = 1'b0;

  always #5 clk = ~clk;

  i2s_serializer #(.SAMPLE_W(SW), .HALF_DIV(HD)) i_i2s_serializer (
    .clk(clk), .rstN(rstN), .mclkEn(mclkEn), .modeIn(modeIn),
    .sampleValid(sampleValid), .leftIn(leftIn), .rightIn(rightIn),
    .bclk(bclk), .wclk(wclk), .sdata(sdata)
  );

  always @(negedge clk) begin
    if (monOn && ((wclk != pw) || (sdata != pd)) && !(pb && !bclk)) edgeErr++;
    if (recOn && bclk && !pb && recN < RECN) begin
      recW[recN] = wclk;
      recD[recN] = sdata;
      recN++;
    end
    pb = bclk; pw = wclk; pd = sdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendPair(input logic [SW-1:0] l, input logic [SW-1:0] r);
    @(negedge clk);
    leftIn = l; rightIn = r; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic record();
    recN = 0;
    recOn = 1'b1;
    while (recN < RECN) @(negedge clk);
    recOn = 1'b0;
  endtask

  // checks one frame starting at the nth left-slot word-clock fall in the capture
  task automatic checkFrame(input int md, input int nth, input logic [SW-1:0] eL,
                            input logic [SW-1:0] eR, input string req);
    int k = -1;
    int seen = 0;
    int st, wBad, lBad, rBad;
    logic [31:0] slotL, slotR;
    bit i2sLike;
    for (int i = 1; i < RECN - 70; i++) begin
      if (k < 0 && recW[i-1] && !recW[i]) begin
        if (seen == nth) k = i;
        seen++;
      end
    end
    check(k >= 0, {req, " frame located"}, k, 0);
    if (k < 0) return;
    i2sLike = (md == 0 || md == 3);
    st = i2sLike ? k + 1 : k;
    slotL = (md == 2) ? 32'(eL) : (32'(eL) << (32 - SW));
    slotR = (md == 2) ? 32'(eR) : (32'(eR) << (32 - SW));
    wBad = 0; lBad = 0; rBad = 0;
    for (int q = 0; q < 64; q++) begin
      logic expW;
      expW = i2sLike ? (((q + 1) % 64) >= 32) : (q >= 32);
      if (recW[st+q] != expW) wBad++;
      if (q < 32) begin
        if (recD[st+q] != slotL[31-q]) lBad++;
      end else begin
        if (recD[st+q] != slotR[63-q]) rBad++;
      end
    end
    check(wBad == 0, {req, " R3 word clock shape"}, wBad, 0);
    check(lBad == 0, {req, " R8 left slot bits"}, lBad, 0);
    check(rBad == 0, {req, " R8 right slot bits"}, rBad, 0);
  endtask

  task automatic testReset();
    waitClk(4);
    check(bclk == 0, "R1 bclk in reset", bclk, 0);
    check(wclk == 0, "R1 wclk in reset", wclk, 0);
    check(sdata == 0, "R1 sdata in reset", sdata, 0);
  endtask

  task automatic testDuty();
    int hi = 0, lo = 0;
    while (bclk) @(negedge clk);
    while (!bclk) @(negedge clk);
    while (bclk) begin hi++; @(negedge clk); end
    while (!bclk) begin lo++; @(negedge clk); end
    check(hi == HD, "R2 high phase", hi, HD);
    check(lo == HD, "R2 low phase", lo, HD);
  endtask

  task automatic testGate();
    logic b0;
    int moved = 0;
    @(negedge clk);
    mclkEn = 1'b0;
    @(negedge clk);
    b0 = bclk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclk != b0) moved++;
    end
    check(moved == 0, "R2 bclk held without enable", moved, 0);
    mclkEn = 1'b1;
  endtask

  task automatic testMode(input int md, input logic [SW-1:0] l, input logic [SW-1:0] r,
                          input string req);
    modeIn = 2'(md);
    sendPair(l, r);
    waitClk(600);
    record();
    checkFrame(md, 0, l, r, req);
  endtask

  task automatic testRepeat(input logic [SW-1:0] l, input logic [SW-1:0] r);
    waitClk(300);
    record();
    checkFrame(1, 0, l, r, "R9 repeat first");
    checkFrame(1, 1, l, r, "R9 repeat second");
  endtask

  task automatic testSwap();
    sendPair(24'h0F0F0F, 24'h123456);
    waitClk(600);
    record();
    checkFrame(1, 0, 24'h0F0F0F, 24'h123456, "R9 new pair at left slot");
  endtask

  initial begin
    #1_000_000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    mclkEn = 1'b1;
    monOn = 1'b1;
    testDuty();
    testGate();
    testMode(1, 24'hA5C381, 24'h5A3C7E, "R5 left-justified");
    testRepeat(24'hA5C381, 24'h5A3C7E);
    testSwap();
    testMode(0, 24'h80F001, 24'h7FFF02, "R6 standard");
    testMode(2, 24'hC00003, 24'h3E0041, "R7 right-justified");
    testMode(3, 24'h9ABCDE, 24'h112233, "R10 mode three");
    check(edgeErr == 0, "R4 transitions on falling bclk", edgeErr, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule